// File: doc/BRIEF.md
# Debug breakpoint and stall unit

This block watches a CPU's instruction-fetch and data-access buses and holds the CPU in a stall when a programmed break condition is met. It has two address-wide breakpoint registers, written as bytes, and a 3-bit condition selector. The selector picks one of three kinds of match. The first is an address-equals compare that also checks the data byte against the low byte of the second register. The second is an inclusive address window. The third is a below-or-equal compare that guards the contents of the stack.

Single-step mode stalls on every instruction start. A software-breakpoint mode stalls when a chosen opcode is fetched at an instruction start. Every cause of a stall leaves a sticky status flag. The debugger resumes the CPU by writing 0 to the stall bit, and it clears each flag in the same way. The stall is registered, so it rises in the cycle after the bus event. For a fetch, that cycle is the first decode cycle of the instruction.

Top module: `dbg_break_unit`

## Requirements
- R1: After a synchronous active-low reset, `cpu_stall`, `flag_brk`, `flag_step` and `flag_sw` are 0 and the condition selector is 0. The top byte of breakpoint register A resets to all ones. Every other byte of both breakpoint registers resets to 0.
- R2: The register map, with N = ADDR_W/8, is as follows. Offsets 0..N-1 hold breakpoint A, low byte first. Offsets N..2N-1 hold breakpoint B. Offset 2N is the control register: bits 2:0 select the condition, bit 3 enables step and bit 4 enables the software break. Offset 2N+1 is the status register. A condition value of 0 produces no address or data break for any bus activity.
- R3: Condition values 1, 2 and 3 break on a data access whose address equals A and whose data byte equals the low byte of B. Value 1 matches writes only (`data_we`=1), value 2 matches reads only, and value 3 matches both.
- R4: Condition 4 breaks on an instruction fetch with A <= address <= B, but only when `fetch_start`=1 marks a valid instruction start.
- R5: Condition 5 breaks on a data write with A <= address <= B. Condition 6 breaks on a data read in the same window.
- R6: Condition 7 breaks on any data access at an address <= A.
- R7: A break, step or software-break event in cycle t sets its flag and `cpu_stall` from cycle t+1, which is the first decode cycle after the fetch.
- R8: With step enabled, every instruction-start fetch sets `flag_step` and stalls. If an instruction break matches the same fetch, `flag_brk` and `flag_step` are both set.
- R9: With the software break enabled, a fetch with `fetch_start`=1 and `fetch_opcode` equal to SWBRK_OP sets `flag_sw` and stalls. The opcode at a non-start fetch, or with the enable clear, has no effect.
- R10: The flags are sticky. In the status register, bit 0 is the break flag, bit 1 the step flag, bit 2 the software-break flag and bit 3 the stall. Writing 0 to a bit clears it, and writing 1 to a bit leaves it unchanged.
- R11: Clearing only the stall bit resumes the CPU and leaves the flags as they were. With step enabled, the next instruction start stalls again.
- R12: Bus events in a cycle where `cpu_stall`=1 are ignored. If an event and a status write that clears a bit fall in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register offset |
| cfg_wdata | input | 8 | Register write data |
| fetch_valid | input | 1 | Instruction fetch on the bus this cycle |
| fetch_start | input | 1 | The fetched byte is a valid instruction start |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_opcode | input | 8 | Fetched opcode byte |
| data_valid | input | 1 | Data access on the bus this cycle |
| data_we | input | 1 | 1 for a write, 0 for a read |
| data_addr | input | ADDR_W | Data access address |
| data_byte | input | 8 | Data byte being written or read |
| cpu_stall | output | 1 | Holds the CPU |
| flag_brk | output | 1 | Sticky condition-break flag |
| flag_step | output | 1 | Sticky step flag |
| flag_sw | output | 1 | Sticky software-break flag |

## Verification
The bench builds the block with the default 24-bit address, which gives a 3-bit register offset and a reset value of FF0000 for breakpoint A. It sets SWBRK_OP to C9 rather than the default, so the opcode match follows the parameter and is not fixed in the logic. The 24-bit width makes it possible to put a three-byte address above and below the reset value of A, and to land exactly on both edges of a window.

// File: rtl/dbg_break_pkg.sv
// Shared types and field positions for the debug breakpoint and stall unit.
// Assumes byte-wide register access and that the address width is a multiple of 8.
package dbg_break_pkg;

    typedef enum logic [2:0] {
        COND_OFF       = 3'd0,
        COND_WR_EQ     = 3'd1,
        COND_RD_EQ     = 3'd2,
        COND_RW_EQ     = 3'd3,
        COND_FETCH_WIN = 3'd4,
        COND_WR_WIN    = 3'd5,
        COND_RD_WIN    = 3'd6,
        COND_STACK_LE  = 3'd7
    } brk_cond_e;

    localparam int CTL_STEP_BIT = 3;
    localparam int CTL_SW_BIT   = 4;

    localparam int ST_BRK_BIT   = 0;
    localparam int ST_STEP_BIT  = 1;
    localparam int ST_SW_BIT    = 2;
    localparam int ST_STALL_BIT = 3;

endpackage

// File: rtl/dbg_break_regs.sv
// Byte-addressed register file: two breakpoint registers, a control register and
// status-write decoding. Assumes writes arrive one byte per cycle on cfg_we.
module dbg_break_regs
    import dbg_break_pkg::*;
#(
    parameter int ADDR_W = 24,
    localparam int NBYTES = ADDR_W / 8,
    localparam int REG_AW = $clog2(2 * NBYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [ADDR_W-1:0] bk_a,
    output logic [ADDR_W-1:0] bk_b,
    output brk_cond_e         cond,
    output logic              step_en,
    output logic              sw_en,
    output logic              st_we,
    output logic [3:0]        st_clr
);

    localparam logic [REG_AW-1:0] CTL_OFS    = REG_AW'(2 * NBYTES);
    localparam logic [REG_AW-1:0] STATUS_OFS = REG_AW'(2 * NBYTES + 1);

    logic [7:0] ctl_q;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] a_q, b_q;

        // Hold byte b of both breakpoint registers; A's top byte resets to ones.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= (b == NBYTES - 1) ? 8'hFF : 8'h00;
                b_q <= 8'h00;
            end else if (cfg_we) begin
                if (cfg_addr == REG_AW'(b))
                    a_q <= cfg_wdata;
                if (cfg_addr == REG_AW'(NBYTES + b))
                    b_q <= cfg_wdata;
            end
        end

        assign bk_a[b*8 +: 8] = a_q;
        assign bk_b[b*8 +: 8] = b_q;
    end

    // Hold the control register (condition, step enable, software-break enable).
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= 8'h00;
        else if (cfg_we && cfg_addr == CTL_OFS)
            ctl_q <= cfg_wdata;
    end

    assign cond    = brk_cond_e'(ctl_q[2:0]);
    assign step_en = ctl_q[CTL_STEP_BIT];
    assign sw_en   = ctl_q[CTL_SW_BIT];

    // Decode a status write into per-bit clear requests (a 0 written clears).
    always_comb begin
        st_we  = cfg_we && (cfg_addr == STATUS_OFS);
        st_clr = st_we ? ~cfg_wdata[3:0] : 4'b0000;
    end

    // R2: a status write never changes the condition selector
    p_status_keeps_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> $stable(ctl_q));

endmodule

// File: rtl/dbg_break_match.sv
// Condition decoder: compares this cycle's bus activity against the two
// breakpoint registers under the selected condition. Purely combinational.
module dbg_break_match
    import dbg_break_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  brk_cond_e         cond,
    input  logic [ADDR_W-1:0] bk_a,
    input  logic [ADDR_W-1:0] bk_b,
    input  logic              fetch_valid,
    input  logic              fetch_start,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_valid,
    input  logic              data_we,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [7:0]        data_byte,
    output logic              brk_hit
);

    logic insn_start, d_wr, d_rd, d_eq, d_win, f_win, d_le;

    // Form the qualified bus strobes and the three kinds of compare.
    always_comb begin
        insn_start = fetch_valid && fetch_start;
        d_wr       = data_valid && data_we;
        d_rd       = data_valid && !data_we;
        d_eq       = (data_addr == bk_a) && (data_byte == bk_b[7:0]);
        d_win      = (data_addr >= bk_a) && (data_addr <= bk_b);
        f_win      = (fetch_addr >= bk_a) && (fetch_addr <= bk_b);
        d_le       = (data_addr <= bk_a);
    end

    // Select the compare that the condition field asks for.
    always_comb begin
        case (cond)
            COND_WR_EQ:     brk_hit = d_wr && d_eq;
            COND_RD_EQ:     brk_hit = d_rd && d_eq;
            COND_RW_EQ:     brk_hit = data_valid && d_eq;
            COND_FETCH_WIN: brk_hit = insn_start && f_win;
            COND_WR_WIN:    brk_hit = d_wr && d_win;
            COND_RD_WIN:    brk_hit = d_rd && d_win;
            COND_STACK_LE:  brk_hit = data_valid && d_le;
            default:        brk_hit = 1'b0;
        endcase
    end

    // R2: the disabled selector never produces a hit
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_OFF) |-> !brk_hit);

    // R4: a fetch-window hit needs a valid instruction start
    p_fetch_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_FETCH_WIN && brk_hit) |-> (fetch_valid && fetch_start));

    // R3: equality conditions never hit without a data access
    p_eq_needs_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond inside {COND_WR_EQ, COND_RD_EQ, COND_RW_EQ} && brk_hit) |-> data_valid);

endmodule

// File: rtl/dbg_break_stall.sv
// Flag and stall sequencer: turns break, step and software-break events into
// sticky flags and a registered stall. Assumes that the CPU presents no new
// events while stalled; any that appear are ignored.
module dbg_break_stall
    import dbg_break_pkg::*;
#(
    parameter logic [7:0] SWBRK_OP = 8'h8B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       brk_hit,
    input  logic       fetch_valid,
    input  logic       fetch_start,
    input  logic [7:0] fetch_opcode,
    input  logic       step_en,
    input  logic       sw_en,
    input  logic       st_we,
    input  logic [3:0] st_clr,
    output logic       cpu_stall,
    output logic       flag_brk,
    output logic       flag_step,
    output logic       flag_sw
);

    logic brk_q, step_q, sw_q, stall_q;
    logic brk_set, step_set, sw_set;

    // Gate the event sources; nothing is taken while already stalled.
    always_comb begin
        brk_set  = !stall_q && brk_hit;
        step_set = !stall_q && step_en && fetch_valid && fetch_start;
        sw_set   = !stall_q && sw_en && fetch_valid && fetch_start
                   && (fetch_opcode == SWBRK_OP);
    end

    // Update the sticky flags and the stall; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_q   <= 1'b0;
            step_q  <= 1'b0;
            sw_q    <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            brk_q   <= brk_set  || (brk_q  && !st_clr[ST_BRK_BIT]);
            step_q  <= step_set || (step_q && !st_clr[ST_STEP_BIT]);
            sw_q    <= sw_set   || (sw_q   && !st_clr[ST_SW_BIT]);
            stall_q <= brk_set || step_set || sw_set
                       || (stall_q && !st_clr[ST_STALL_BIT]);
        end
    end

    assign cpu_stall = stall_q;
    assign flag_brk  = brk_q;
    assign flag_step = step_q;
    assign flag_sw   = sw_q;

    // R7: a stall only begins together with a recorded cause
    p_stall_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_q) |-> (brk_q || step_q || sw_q));

    // R12: no flag rises from a cycle in which the CPU was stalled
    p_frozen_while_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q |=> !($rose(brk_q) || $rose(step_q) || $rose(sw_q)));

    // R11: the stall drops only after a status write that clears it
    p_release_by_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_q) |-> $past(st_we && st_clr[ST_STALL_BIT]));

    // R10: a flag stays set unless a write clears it
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !st_clr[ST_BRK_BIT]) |=> brk_q);

endmodule

// File: rtl/dbg_break_unit.sv
// Top of the debug breakpoint and stall unit: register file, condition decoder
// and stall sequencer. Assumes the CPU honours cpu_stall in the cycle it is high.
module dbg_break_unit
    import dbg_break_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [7:0]  SWBRK_OP = 8'h8B,
    localparam int         NBYTES   = ADDR_W / 8,
    localparam int         REG_AW   = $clog2(2 * NBYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              fetch_valid,
    input  logic              fetch_start,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [7:0]        fetch_opcode,
    input  logic              data_valid,
    input  logic              data_we,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [7:0]        data_byte,
    output logic              cpu_stall,
    output logic              flag_brk,
    output logic              flag_step,
    output logic              flag_sw
);

    logic [ADDR_W-1:0] bk_a, bk_b;
    brk_cond_e         cond;
    logic              step_en, sw_en, st_we, brk_hit;
    logic [3:0]        st_clr;

    dbg_break_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bk_a(bk_a), .bk_b(bk_b), .cond(cond),
        .step_en(step_en), .sw_en(sw_en), .st_we(st_we), .st_clr(st_clr)
    );

    dbg_break_match #(.ADDR_W(ADDR_W)) match_i (
        .clk(clk), .rst_n(rst_n), .cond(cond), .bk_a(bk_a), .bk_b(bk_b),
        .fetch_valid(fetch_valid), .fetch_start(fetch_start),
        .fetch_addr(fetch_addr), .data_valid(data_valid), .data_we(data_we),
        .data_addr(data_addr), .data_byte(data_byte), .brk_hit(brk_hit)
    );

    dbg_break_stall #(.SWBRK_OP(SWBRK_OP)) stall_i (
        .clk(clk), .rst_n(rst_n), .brk_hit(brk_hit),
        .fetch_valid(fetch_valid), .fetch_start(fetch_start),
        .fetch_opcode(fetch_opcode), .step_en(step_en), .sw_en(sw_en),
        .st_we(st_we), .st_clr(st_clr), .cpu_stall(cpu_stall),
        .flag_brk(flag_brk), .flag_step(flag_step), .flag_sw(flag_sw)
    );

endmodule

// File: tb/dbg_break_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_break_unit_tb_top;

    localparam logic [7:0] SW_OP = 8'hC9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        fetch_valid = 1'b0, fetch_start = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic [7:0]  fetch_opcode = '0;
    logic        data_valid = 1'b0, data_we = 1'b0;
    logic [23:0] data_addr = '0;
    logic [7:0]  data_byte = '0;
    logic        cpu_stall, flag_brk, flag_step, flag_sw;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done = 1'b0;
    bit    started = 1'b0;

    always #2.5 clk = ~clk;

    dbg_break_unit #(.ADDR_W(24), .SWBRK_OP(SW_OP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_start(fetch_start),
        .fetch_addr(fetch_addr), .fetch_opcode(fetch_opcode),
        .data_valid(data_valid), .data_we(data_we), .data_addr(data_addr),
        .data_byte(data_byte), .cpu_stall(cpu_stall), .flag_brk(flag_brk),
        .flag_step(flag_step), .flag_sw(flag_sw)
    );

    // Behavioural reference model, advanced on every rising edge.
    logic [23:0] m_a, m_b;
    int          m_cond;
    bit          m_step_en, m_sw_en, m_brk, m_stp, m_sw, m_stall;
    bit          hb, hs, hw;

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_a = 24'hFF0000; m_b = 24'h0; m_cond = 0;
            m_step_en = 0; m_sw_en = 0;
            m_brk = 0; m_stp = 0; m_sw = 0; m_stall = 0;
        end else begin
            hb = 0; hs = 0; hw = 0;
            if (!m_stall) begin
                case (m_cond)
                    1: hb = data_valid && data_we && data_addr == m_a && data_byte == m_b[7:0];
                    2: hb = data_valid && !data_we && data_addr == m_a && data_byte == m_b[7:0];
                    3: hb = data_valid && data_addr == m_a && data_byte == m_b[7:0];
                    4: hb = fetch_valid && fetch_start && fetch_addr >= m_a && fetch_addr <= m_b;
                    5: hb = data_valid && data_we && data_addr >= m_a && data_addr <= m_b;
                    6: hb = data_valid && !data_we && data_addr >= m_a && data_addr <= m_b;
                    7: hb = data_valid && data_addr <= m_a;
                    default: hb = 0;
                endcase
                hs = m_step_en && fetch_valid && fetch_start;
                hw = m_sw_en && fetch_valid && fetch_start && fetch_opcode == SW_OP;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_a[7:0]   = cfg_wdata;
                    3'd1: m_a[15:8]  = cfg_wdata;
                    3'd2: m_a[23:16] = cfg_wdata;
                    3'd3: m_b[7:0]   = cfg_wdata;
                    3'd4: m_b[15:8]  = cfg_wdata;
                    3'd5: m_b[23:16] = cfg_wdata;
                    3'd6: begin
                        m_cond = int'(cfg_wdata[2:0]);
                        m_step_en = cfg_wdata[3];
                        m_sw_en = cfg_wdata[4];
                    end
                    default: begin
                        if (!cfg_wdata[0]) m_brk = 0;
                        if (!cfg_wdata[1]) m_stp = 0;
                        if (!cfg_wdata[2]) m_sw = 0;
                        if (!cfg_wdata[3]) m_stall = 0;
                    end
                endcase
            end
            if (hb) m_brk = 1;
            if (hs) m_stp = 1;
            if (hw) m_sw = 1;
            if (hb || hs || hw) m_stall = 1;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Compare the design with the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "model stall", cpu_stall, m_stall);
            chk(cur_req, "model brk",   flag_brk,  m_brk);
            chk(cur_req, "model step",  flag_step, m_stp);
            chk(cur_req, "model sw",    flag_sw,   m_sw);
        end
    end

    // Each task starts just after a falling edge and returns after the next one.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic fetch(input logic [23:0] a, input logic [7:0] op, input logic st);
        fetch_valid = 1; fetch_start = st; fetch_addr = a; fetch_opcode = op;
        @(negedge clk);
        fetch_valid = 0; fetch_start = 0;
    endtask

    task automatic dacc(input logic we, input logic [23:0] a, input logic [7:0] d);
        data_valid = 1; data_we = we; data_addr = a; data_byte = d;
        @(negedge clk);
        data_valid = 0;
    endtask

    task automatic expect4(input string req, input logic s, input logic b,
                           input logic p, input logic w);
        chk(req, "stall", cpu_stall, s);
        chk(req, "flag_brk", flag_brk, b);
        chk(req, "flag_step", flag_step, p);
        chk(req, "flag_sw", flag_sw, w);
    endtask

    task automatic clear_all();
        wr(3'd7, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        expect4("R1", 0, 0, 0, 0);
        // R1: A's top byte resets to FF -> 0x123456 <= 0xFF0000 under condition 7
        wr(3'd6, 8'h07);
        dacc(0, 24'h123456, 8'h00);
        expect4("R1", 1, 1, 0, 0);
        clear_all();
        expect4("R10", 0, 0, 0, 0);

        cur_req = "R2";
        wr(3'd6, 8'h00);
        dacc(1, 24'h000000, 8'h00);
        fetch(24'h000000, 8'h00, 1);
        expect4("R2", 0, 0, 0, 0);

        cur_req = "R3";
        wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd2, 8'h00); wr(3'd3, 8'h5A);
        wr(3'd6, 8'h01);
        dacc(1, 24'h001234, 8'h5B); chk("R3", "write wrong data", cpu_stall, 0);
        dacc(0, 24'h001234, 8'h5A); chk("R3", "read under write-only", cpu_stall, 0);
        dacc(1, 24'h001235, 8'h5A); chk("R3", "write wrong addr", cpu_stall, 0);
        dacc(1, 24'h001234, 8'h5A);
        expect4("R7", 1, 1, 0, 0);
        clear_all();
        wr(3'd6, 8'h02);
        dacc(1, 24'h001234, 8'h5A); chk("R3", "write under read-only", cpu_stall, 0);
        dacc(0, 24'h001234, 8'h5A); chk("R3", "read match", cpu_stall, 1);
        clear_all();
        wr(3'd6, 8'h03);
        dacc(1, 24'h001234, 8'h5A); chk("R3", "either: write", cpu_stall, 1);
        clear_all();
        dacc(0, 24'h001234, 8'h5A); chk("R3", "either: read", cpu_stall, 1);
        clear_all();

        cur_req = "R4";
        wr(3'd0, 8'h00); wr(3'd1, 8'h80);
        wr(3'd3, 8'h10); wr(3'd4, 8'h80); wr(3'd5, 8'h00);
        wr(3'd6, 8'h04);
        fetch(24'h008011, 8'h00, 1); chk("R4", "above window", cpu_stall, 0);
        fetch(24'h007FFF, 8'h00, 1); chk("R4", "below window", cpu_stall, 0);
        fetch(24'h008005, 8'h00, 0); chk("R4", "not an instruction start", cpu_stall, 0);
        dacc(1, 24'h008005, 8'h00);  chk("R4", "data access ignored", cpu_stall, 0);
        fetch(24'h008010, 8'h00, 1); chk("R4", "upper edge", cpu_stall, 1);
        clear_all();
        fetch(24'h008000, 8'h00, 1); chk("R4", "lower edge", cpu_stall, 1);
        clear_all();

        cur_req = "R5";
        wr(3'd6, 8'h05);
        dacc(0, 24'h008008, 8'h00); chk("R5", "read under write window", cpu_stall, 0);
        dacc(1, 24'h008008, 8'h00); chk("R5", "write in window", cpu_stall, 1);
        clear_all();
        wr(3'd6, 8'h06);
        dacc(1, 24'h008010, 8'h00); chk("R5", "write under read window", cpu_stall, 0);
        dacc(0, 24'h008011, 8'h00); chk("R5", "read above window", cpu_stall, 0);
        dacc(0, 24'h008010, 8'h00); chk("R5", "read at upper edge", cpu_stall, 1);
        clear_all();

        cur_req = "R6";
        wr(3'd6, 8'h07);
        dacc(0, 24'h008001, 8'h00); chk("R6", "above A", cpu_stall, 0);
        dacc(0, 24'h008000, 8'h00); chk("R6", "equal A", cpu_stall, 1);
        clear_all();
        dacc(1, 24'h007000, 8'h00); chk("R6", "write below A", cpu_stall, 1);
        clear_all();

        cur_req = "R8";
        wr(3'd6, 8'h08);
        fetch(24'h009000, 8'h00, 1);
        expect4("R8", 1, 0, 1, 0);
        cur_req = "R11";
        wr(3'd7, 8'h07);
        expect4("R11", 0, 0, 1, 0);
        fetch(24'h009001, 8'h00, 0); chk("R11", "non-start fetch", cpu_stall, 0);
        fetch(24'h009002, 8'h00, 1); chk("R11", "step stalls again", cpu_stall, 1);
        cur_req = "R10";
        wr(3'd7, 8'hFF);
        expect4("R10", 1, 0, 1, 0);
        clear_all();

        cur_req = "R8";
        wr(3'd6, 8'h0C);
        fetch(24'h008004, 8'h00, 1);
        expect4("R8", 1, 1, 1, 0);
        cur_req = "R12";
        wr(3'd7, 8'h0E);
        chk("R12", "brk cleared", flag_brk, 0);
        fetch(24'h008004, 8'h00, 1);
        chk("R12", "event while stalled ignored", flag_brk, 0);
        clear_all();
        // R12: an event and a clearing write in the same cycle; the event wins
        cfg_we = 1; cfg_addr = 3'd7; cfg_wdata = 8'h00;
        fetch_valid = 1; fetch_start = 1; fetch_addr = 24'h008004;
        @(negedge clk);
        cfg_we = 0; fetch_valid = 0; fetch_start = 0;
        expect4("R12", 1, 1, 1, 0);
        clear_all();

        cur_req = "R9";
        wr(3'd6, 8'h10);
        fetch(24'h00A000, SW_OP, 0); chk("R9", "opcode at non-start", cpu_stall, 0);
        fetch(24'h00A000, 8'h9D, 1); chk("R9", "other opcode", cpu_stall, 0);
        fetch(24'h00A000, SW_OP, 1);
        expect4("R9", 1, 0, 0, 1);
        clear_all();
        wr(3'd6, 8'h00);
        fetch(24'h00A000, SW_OP, 1); chk("R9", "enable clear", flag_sw, 0);

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule